// File: doc/BRIEF.md
# Pseudo-Random Bit Stream Generator with Error Insertion

This block emits a serial maximal-length pseudo-random sequence, one bit for every cycle on which the bit enable is high. The sequence order is chosen at run time from seven codes, and each order repeats after 2^N−1 bits. A sync output marks the first bit of every repetition, so a receiver or a scope can lock onto the sequence.

Errors can be put into the stream deliberately. Three modes are offered: a one-off error on request, a periodic error every 10^n bits, or an error for each external strobe. Each error inverts exactly one output bit and is flagged on a separate output. A field select limits insertion to overhead bits, to payload bits, or lets it fall on any bit. The overhead/payload marker comes with every bit. If the error falls due on a bit outside the allowed field, it waits for the next allowed bit. An inhibit input blanks the data while it is high, and the sequence keeps advancing underneath it.

Order, injection mode and rate exponent are captured only on reset or on a synchronous restart. A restart also reloads the seed and clears the rate count and any pending error.

Top module: `prbs_err_gen`

## Requirements
- R1: Order code 0..6 selects N = 7, 9, 10, 11, 15, 23, 31, and code 7 selects 31. The feedback is bit N XOR bit M of x^N + x^M + 1, with M = 6, 5, 7, 9, 14, 18, 28 respectively. The state is seeded with all ones and shifts left, and the oldest bit (bit N−1) is the output. The first N bits after a restart are therefore all 1.
- R2: `sync_pulse` is high alongside each bit that starts a period (the state equals the seed). Successive pulses are 2^N−1 enabled bits apart, and the first is on bit 0 after a restart.
- R3: `dout` changes only one cycle after a cycle with `bit_en` high, or after a restart. `sync_pulse` and `err_flag` are low after any cycle without `bit_en`.
- R4: `order_sel`, `inj_mode` and `rate_exp` are captured on reset or on `restart`; changing them at other times has no effect. After a restart the outputs are 0, the seed is reloaded, the rate count is cleared and any pending error is dropped.
- R5: With mode code 1 (single), a pulse on `single_req` (on any cycle) arms one error, which is inserted on the next allowed bit. Several requests before insertion merge into one.
- R6: With mode code 2 (rate), an error falls due on enabled bits 10^n, 2·10^n, … counted from the restart, where n = `rate_exp` clamped to 3..7.
- R7: With mode code 3 (external), `ext_strobe` arms an error in the same way as R5. A strobe on an allowed enabled bit inverts that very bit.
- R8: The `field_sel` code is 1 for overhead only (`ovh_flag` = 1), 2 for payload only (`ovh_flag` = 0), and 0 or 3 for any bit. An error falling due outside the allowed field is deferred to the next allowed bit.
- R9: On an enabled bit with `inhibit` high, `dout` is 0 and `err_flag` is 0. The sequence still advances, and a due error is deferred.
- R10: `err_flag` is high exactly alongside an inverted bit, so `dout` equals the sequence bit XOR `err_flag`.
- R11: With mode code 0 no errors are inserted, and requests that belong to a mode other than the captured one are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also captures configuration |
| bit_en | input | 1 | Advance one bit this cycle |
| restart | input | 1 | Synchronous restart: capture configuration, reseed |
| order_sel | input | 3 | Sequence order code |
| inj_mode | input | 2 | 0 off, 1 single, 2 rate, 3 external |
| rate_exp | input | 3 | Decade exponent for rate mode |
| field_sel | input | 2 | Field allowed for insertion |
| ovh_flag | input | 1 | Current bit is overhead (1) or payload (0) |
| inhibit | input | 1 | Blank the data output for this bit |
| single_req | input | 1 | One-off error request |
| ext_strobe | input | 1 | External error strobe |
| dout | output | 1 | Serial data |
| err_flag | output | 1 | Current output bit is inverted |
| sync_pulse | output | 1 | First bit of a sequence period |

## Verification
On every cycle the assertions check several local rules. Nothing moves or pulses without an enabled bit. A restart clears the outputs. An inhibited bit is blank and error-free. No error lands outside the selected field or while injection is off. A pending error is consumed by the insertion that flags it. Whether the bit values follow the right polynomial, whether sync pulses are a full period apart, and where periodic, deferred and strobed errors land can only be shown by the bench's scenarios. The bench compares every bit against an independent model.

// File: rtl/prbs_pkg.sv
`timescale 1ns/1ps
package prbs_pkg;

  typedef enum logic [1:0] {
    INJ_OFF    = 2'd0,
    INJ_SINGLE = 2'd1,
    INJ_RATE   = 2'd2,
    INJ_EXT    = 2'd3
  } inj_mode_e;

  localparam logic [1:0] FLD_OVH = 2'd1;
  localparam logic [1:0] FLD_PAY = 2'd2;

  // index of the oldest state bit (N-1) for an order code
  function automatic logic [4:0] order_top(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd6;
      3'd1:    return 5'd8;
      3'd2:    return 5'd9;
      3'd3:    return 5'd10;
      3'd4:    return 5'd14;
      3'd5:    return 5'd22;
      default: return 5'd30;
    endcase
  endfunction

  // index of the second feedback tap (M-1)
  function automatic logic [4:0] order_tap(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd5;
      3'd1:    return 5'd4;
      3'd2:    return 5'd6;
      3'd3:    return 5'd8;
      3'd4:    return 5'd13;
      3'd5:    return 5'd17;
      default: return 5'd27;
    endcase
  endfunction

  function automatic logic [31:0] order_mask(input logic [2:0] code);
    logic [31:0] m;
    logic [4:0]  t;
    t = order_top(code);
    for (int i = 0; i < 32; i++) m[i] = (i <= int'(t));
    return m;
  endfunction

endpackage

// File: rtl/prbs_lfsr.sv
`timescale 1ns/1ps
module prbs_lfsr
  import prbs_pkg::*;
#(
  parameter int STATE_W = 31
) (
  input  logic       clk,
  input  logic       load,
  input  logic       step,
  input  logic [2:0] order,
  output logic       cur_bit,
  output logic       at_seed
);
  logic [STATE_W-1:0] state, nxt, seed;
  logic [4:0] top_i, tap_i;
  logic fb;

  always_comb begin
    logic [31:0] full;
    full    = order_mask(order);
    seed    = full[STATE_W-1:0];
    top_i   = order_top(order);
    tap_i   = order_tap(order);
    cur_bit = state[top_i];
    fb      = state[top_i] ^ state[tap_i];
    nxt     = {state[STATE_W-2:0], fb} & seed;
    at_seed = (state == seed);
  end

  always_ff @(posedge clk) begin
    if (load)      state <= seed;
    else if (step) state <= nxt;
  end
endmodule

// File: rtl/prbs_rate_timer.sv
`timescale 1ns/1ps
module prbs_rate_timer #(
  parameter int MIN_EXP = 3,
  parameter int MAX_EXP = 7,
  parameter int CNT_W   = 24
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       step,
  input  logic [2:0] exp_code,
  output logic       due
);
  logic [CNT_W-1:0] cnt, last;

  function automatic logic [CNT_W-1:0] decade(input logic [2:0] code);
    int e;
    logic [CNT_W-1:0] p;
    e = int'(code);
    if (e < MIN_EXP) e = MIN_EXP;
    if (e > MAX_EXP) e = MAX_EXP;
    p = CNT_W'(1);
    for (int k = 0; k < MAX_EXP; k++)
      if (k < e) p = CNT_W'(p * 10);
    return p;
  endfunction

  always_comb begin
    last = decade(exp_code) - CNT_W'(1);
    due  = step && (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (clr)       cnt <= '0;
    else if (step) cnt <= due ? '0 : cnt + CNT_W'(1);
  end
endmodule

// File: rtl/prbs_inject_ctrl.sv
`timescale 1ns/1ps
module prbs_inject_ctrl
  import prbs_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  inj_mode_e  mode,
  input  logic [1:0] field_sel,
  input  logic       ovh_flag,
  input  logic       inhibit,
  input  logic       step,
  input  logic       single_req,
  input  logic       ext_strobe,
  input  logic       due,
  output logic       inject,
  output logic       pend
);
  logic req_now, fld_ok, slot_ok;

  always_comb begin
    case (mode)
      INJ_SINGLE: req_now = single_req;
      INJ_RATE:   req_now = due;
      INJ_EXT:    req_now = ext_strobe;
      default:    req_now = 1'b0;
    endcase
    case (field_sel)
      FLD_OVH: fld_ok = ovh_flag;
      FLD_PAY: fld_ok = !ovh_flag;
      default: fld_ok = 1'b1;
    endcase
    slot_ok = step && !inhibit && fld_ok;
    inject  = slot_ok && (pend || req_now);
  end

  always_ff @(posedge clk) begin
    if (clr || inject) pend <= 1'b0;
    else if (req_now)  pend <= 1'b1;
  end
endmodule

// File: rtl/prbs_err_gen.sv
`timescale 1ns/1ps
module prbs_err_gen
  import prbs_pkg::*;
#(
  parameter int STATE_W = 31,
  parameter int MIN_EXP = 3,
  parameter int MAX_EXP = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       restart,
  input  logic [2:0] order_sel,
  input  logic [1:0] inj_mode,
  input  logic [2:0] rate_exp,
  input  logic [1:0] field_sel,
  input  logic       ovh_flag,
  input  logic       inhibit,
  input  logic       single_req,
  input  logic       ext_strobe,
  output logic       dout,
  output logic       err_flag,
  output logic       sync_pulse
);
  localparam int CNT_W = $clog2(10 ** MAX_EXP);

  logic       cfg_load;
  logic [2:0] order_q, exp_q, order_eff;
  inj_mode_e  mode_q;
  logic       seq_bit, at_seed, due, inject, pend;

  assign cfg_load  = rst || restart;
  assign order_eff = cfg_load ? order_sel : order_q;

  always_ff @(posedge clk) begin
    if (cfg_load) begin
      order_q <= order_sel;
      mode_q  <= inj_mode_e'(inj_mode);
      exp_q   <= rate_exp;
    end
  end

  prbs_lfsr #(.STATE_W(STATE_W)) lfsr_i (
    .clk(clk), .load(cfg_load), .step(bit_en), .order(order_eff),
    .cur_bit(seq_bit), .at_seed(at_seed)
  );

  prbs_rate_timer #(.MIN_EXP(MIN_EXP), .MAX_EXP(MAX_EXP), .CNT_W(CNT_W)) timer_i (
    .clk(clk), .clr(cfg_load), .step(bit_en), .exp_code(exp_q), .due(due)
  );

  prbs_inject_ctrl inj_i (
    .clk(clk), .clr(cfg_load), .mode(mode_q), .field_sel(field_sel),
    .ovh_flag(ovh_flag), .inhibit(inhibit), .step(bit_en),
    .single_req(single_req), .ext_strobe(ext_strobe), .due(due),
    .inject(inject), .pend(pend)
  );

  always_ff @(posedge clk) begin
    if (cfg_load) begin
      dout       <= 1'b0;
      err_flag   <= 1'b0;
      sync_pulse <= 1'b0;
    end else if (bit_en) begin
      dout       <= inhibit ? 1'b0 : (seq_bit ^ inject);
      err_flag   <= inject;
      sync_pulse <= at_seed;
    end else begin
      err_flag   <= 1'b0;
      sync_pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/prbs_err_gen_chk.sv
`timescale 1ns/1ps
module prbs_err_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       bit_en,
  input logic       restart,
  input logic [1:0] field_sel,
  input logic       ovh_flag,
  input logic       inhibit,
  input logic       dout,
  input logic       err_flag,
  input logic       sync_pulse,
  input logic [1:0] mode_q,
  input logic       pend
);
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (!bit_en && !restart) |=> (!sync_pulse && !err_flag && $stable(dout)));

  assert_restart_clears_R4: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!dout && !err_flag && !sync_pulse));

  assert_err_consumes_pending_R5: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> !pend);

  assert_no_err_outside_ovh_R8: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !restart && field_sel == 2'd1 && !ovh_flag) |=> !err_flag);

  assert_no_err_outside_pay_R8: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !restart && field_sel == 2'd2 && ovh_flag) |=> !err_flag);

  assert_inhibit_blanks_R9: assert property (@(posedge clk) disable iff (rst)
    (bit_en && inhibit && !restart) |=> (!dout && !err_flag));

  assert_off_no_err_R11: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd0 && !restart) |=> !err_flag);
endmodule

bind prbs_err_gen prbs_err_gen_chk chk_i (
  .clk(clk), .rst(rst), .bit_en(bit_en), .restart(restart),
  .field_sel(field_sel), .ovh_flag(ovh_flag), .inhibit(inhibit),
  .dout(dout), .err_flag(err_flag), .sync_pulse(sync_pulse),
  .mode_q(mode_q), .pend(pend)
);

// File: tb/prbs_err_gen_tb_top.sv
`timescale 1ns/1ps
module prbs_err_gen_tb_top;
  logic clk = 1'b0;
  logic rst, bit_en, restart, ovh_flag, inhibit, single_req, ext_strobe;
  logic [2:0] order_sel, rate_exp;
  logic [1:0] inj_mode, field_sel;
  logic dout, err_flag, sync_pulse;

  int nchecks = 0, nfail = 0, bitno = 0;
  int m_n, m_t;
  logic [31:0] m_state, m_mask;

  always #2.5 clk = ~clk;

  prbs_err_gen dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .restart(restart),
    .order_sel(order_sel), .inj_mode(inj_mode), .rate_exp(rate_exp),
    .field_sel(field_sel), .ovh_flag(ovh_flag), .inhibit(inhibit),
    .single_req(single_req), .ext_strobe(ext_strobe),
    .dout(dout), .err_flag(err_flag), .sync_pulse(sync_pulse)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic set_model(input logic [2:0] code);
    case (code)
      3'd0: begin m_n = 7;  m_t = 6;  end
      3'd1: begin m_n = 9;  m_t = 5;  end
      3'd2: begin m_n = 10; m_t = 7;  end
      3'd3: begin m_n = 11; m_t = 9;  end
      3'd4: begin m_n = 15; m_t = 14; end
      3'd5: begin m_n = 23; m_t = 18; end
      default: begin m_n = 31; m_t = 28; end
    endcase
    m_mask  = (32'h1 << m_n) - 32'h1;
    m_state = m_mask;
    bitno   = 0;
  endtask

  task automatic do_restart(input logic [2:0] ord, input logic [1:0] md,
                            input logic [2:0] ex, input logic [1:0] fs);
    order_sel = ord; inj_mode = md; rate_exp = ex; field_sel = fs;
    bit_en = 0; restart = 1;
    @(posedge clk); @(negedge clk);
    restart = 0;
    chk(!dout && !err_flag && !sync_pulse, "R4", "outputs after restart",
        {dout, err_flag, sync_pulse}, 0);
    set_model(ord);
  endtask

  task automatic idle(input int n, input logic sreq, input logic xreq);
    for (int i = 0; i < n; i++) begin
      logic prev;
      prev = dout;
      bit_en = 0; single_req = sreq; ext_strobe = xreq;
      @(posedge clk); @(negedge clk);
      single_req = 0; ext_strobe = 0;
      chk(dout == prev, "R3", "dout held without enable", dout, prev);
      chk(!sync_pulse && !err_flag, "R3", "no pulses without enable",
          {sync_pulse, err_flag}, 0);
    end
  endtask

  task automatic one_bit(input logic ovh, input logic inh, input logic strb,
                         output logic got_err);
    logic exp_bit, exp_sync, fb;
    exp_bit  = m_state[m_n-1];
    exp_sync = (m_state == m_mask);
    bit_en = 1; ovh_flag = ovh; inhibit = inh;
    single_req = strb; ext_strobe = strb;
    @(posedge clk); @(negedge clk);
    bit_en = 0; single_req = 0; ext_strobe = 0; inhibit = 0;
    chk(sync_pulse == exp_sync, "R2", "sync at period start", sync_pulse, exp_sync);
    if (inh) begin
      chk(!dout && !err_flag, "R9", "inhibited bit blank", {dout, err_flag}, 0);
    end else begin
      chk(dout == (exp_bit ^ err_flag), "R10", "bit vs sequence xor flag",
          dout, exp_bit ^ err_flag);
    end
    got_err = err_flag;
    fb = m_state[m_n-1] ^ m_state[m_t-1];
    m_state = ((m_state << 1) | {31'b0, fb}) & m_mask;
    bitno++;
  endtask

  task automatic t_reset;
    chk(!dout && !err_flag && !sync_pulse, "R4", "outputs after reset",
        {dout, err_flag, sync_pulse}, 0);
  endtask

  task automatic t_sequence(input logic [2:0] code);
    int p, nsync, last;
    logic e;
    do_restart(code, 2'd0, 3'd3, 2'd0);
    p = (1 << m_n) - 1; nsync = 0; last = -1;
    for (int i = 0; i <= p; i++) begin
      one_bit(1'b0, 1'b0, 1'b0, e);
      if (i < m_n) chk(dout == 1'b1, "R1", "leading ones after seed", dout, 1);
      if (sync_pulse) begin nsync++; last = i; end
    end
    chk(nsync == 2, "R2", "sync count over one period", nsync, 2);
    chk(last == p, "R2", "sync spacing", last, p);
  endtask

  task automatic t_hold;
    logic e;
    do_restart(3'd0, 2'd0, 3'd3, 2'd0);
    for (int i = 0; i < 9; i++) one_bit(1'b0, 1'b0, 1'b0, e);
    idle(4, 1'b0, 1'b0);
  endtask

  task automatic t_single;
    int cnt, pos;
    logic e;
    do_restart(3'd1, 2'd1, 3'd3, 2'd1);
    idle(1, 1'b1, 1'b0);
    idle(1, 1'b1, 1'b0);
    cnt = 0; pos = -1;
    for (int i = 0; i < 20; i++) begin
      one_bit(i >= 4, 1'b0, 1'b0, e);
      if (e) begin cnt++; pos = i; end
    end
    chk(cnt == 1, "R5", "merged single requests", cnt, 1);
    chk(pos == 4, "R8", "deferred to first overhead bit", pos, 4);
  endtask

  task automatic t_rate(input logic [2:0] ex, input int lim, input int nbits);
    int cnt, first, second;
    logic e;
    do_restart(3'd0, 2'd2, ex, 2'd0);
    cnt = 0; first = -1; second = -1;
    for (int i = 0; i < nbits; i++) begin
      one_bit(1'b0, 1'b0, 1'b0, e);
      if (e) begin
        cnt++;
        if (first < 0) first = i; else second = i;
      end
    end
    chk(first == lim - 1, "R6", "first periodic error position", first, lim - 1);
    if (nbits >= 2 * lim) begin
      chk(cnt == 2, "R6", "periodic error count", cnt, 2);
      chk(second == 2 * lim - 1, "R6", "second periodic error", second, 2 * lim - 1);
    end else begin
      chk(cnt == 1, "R6", "periodic error count", cnt, 1);
    end
  endtask

  task automatic t_rate_defer;
    int cnt, pos;
    logic e;
    do_restart(3'd2, 2'd2, 3'd3, 2'd2);
    cnt = 0; pos = -1;
    for (int i = 0; i < 1010; i++) begin
      one_bit(i >= 995 && i <= 1003, 1'b0, 1'b0, e);
      if (e) begin cnt++; pos = i; end
    end
    chk(cnt == 1, "R8", "one deferred periodic error", cnt, 1);
    chk(pos == 1004, "R8", "deferred to first payload bit", pos, 1004);
  endtask

  task automatic t_ext;
    int cnt, p1, p2;
    logic e;
    do_restart(3'd3, 2'd3, 3'd3, 2'd0);
    cnt = 0; p1 = -1; p2 = -1;
    for (int i = 0; i < 30; i++) begin
      one_bit(1'b0, i >= 20 && i <= 22, i == 10 || i == 20, e);
      if (e) begin
        cnt++;
        if (p1 < 0) p1 = i; else p2 = i;
      end
    end
    chk(cnt == 2, "R7", "strobed error count", cnt, 2);
    chk(p1 == 10, "R7", "strobe hits same bit", p1, 10);
    chk(p2 == 23, "R9", "error deferred past inhibit", p2, 23);
    idle(1, 1'b1, 1'b0);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      one_bit(1'b0, 1'b0, 1'b0, e);
      if (e) cnt++;
    end
    chk(cnt == 0, "R11", "single request ignored in external mode", cnt, 0);
  endtask

  task automatic t_latch;
    int cnt, nsync;
    logic e;
    do_restart(3'd0, 2'd0, 3'd3, 2'd0);
    inj_mode = 2'd1; order_sel = 3'd6;
    idle(1, 1'b1, 1'b1);
    cnt = 0; nsync = 0;
    for (int i = 0; i < 200; i++) begin
      one_bit(1'b0, 1'b0, 1'b1, e);
      if (e) cnt++;
      if (sync_pulse) nsync++;
    end
    chk(cnt == 0, "R11", "no errors with injection off", cnt, 0);
    chk(nsync == 2, "R4", "order change without restart ignored", nsync, 2);
  endtask

  initial begin
    #750000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end

  initial begin
    rst = 1; bit_en = 0; restart = 0; ovh_flag = 0; inhibit = 0;
    single_req = 0; ext_strobe = 0; order_sel = 3'd0; inj_mode = 2'd0;
    rate_exp = 3'd3; field_sel = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    set_model(3'd0);
    t_reset();
    t_sequence(3'd0);
    t_sequence(3'd1);
    t_sequence(3'd2);
    t_sequence(3'd3);
    t_hold();
    t_single();
    t_rate(3'd3, 1000, 2001);
    t_rate(3'd1, 1000, 1000);
    t_rate(3'd4, 10000, 10000);
    t_rate_defer();
    t_ext();
    t_latch();
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end
endmodule